// File: doc/BRIEF.md
# Buffered Pulse Transmitter Serializer

This block drives the keying line of an on-off-keyed pulse radio from a byte-wide transmit buffer. Software places a complete frame in the buffer beforehand: preamble, synchronization header and payload all sit there as plain bytes. A start request tells the block where the frame begins and how many bytes it spans. The block then reads the bytes in turn and sends them one bit per tick of a bit-rate enable. A one bit turns the pulse generator on for that bit period and a zero bit keeps it off.

When requested, the block latches a 16-bit free-running tick counter at the moment the frame is accepted. It sends that value after the last buffer byte, so the receiver can tell when the frame was launched. The buffer holds 2048 bytes and has a synchronous read port with one cycle of latency. The block fetches each byte one byte period before it is needed, so the bit stream never stalls after the first bit.

Top module: `pulse_tx_serializer`

## Requirements
- R1: After reset, `busy`, `on_air`, `pulse_en`, `done` and `mem_rd_en` are all low.
- R2: A `start` seen while idle, with `cfg_len` nonzero or `cfg_stamp_en` high, is accepted. `busy` is high from the cycle after that edge until the cycle in which `done` is high, and falls only together with `done`.
- R3: The buffer bytes sent are those at `cfg_base`, `cfg_base+1`, and so on, `cfg_len` of them (0 to 2048). Addresses wrap modulo 2048. Read data is taken from `mem_rd_data` one cycle after `mem_rd_en` is high.
- R4: Each byte is sent most significant bit first, one bit per edge at which `bit_tick` is high. While a bit is on air, `on_air` is high and `pulse_en` equals the bit (1 = pulse on, 0 = pulse off).
- R5: `pulse_en` and `on_air` change only at edges where `bit_tick` is high, and `pulse_en` is low whenever `on_air` is low.
- R6: With `cfg_stamp_en` high, 16 more bits follow the last buffer byte, most significant bit first. Their value is the number of `bit_tick` edges since reset, modulo 65536, counted before the edge that accepted the frame.
- R7: With `cfg_len` zero and `cfg_stamp_en` high, the frame consists of the 16 timestamp bits only.
- R8: A `start` with `cfg_len` zero and `cfg_stamp_en` low is ignored. `busy` stays low and no `done` follows.
- R9: A `start` while `busy` is ignored, whatever the configuration inputs then hold. The frame in progress continues unchanged, and only one `done` is produced.
- R10: `done` is high for exactly one cycle, the cycle after the tick edge that ends the last bit. In that cycle `on_air` and `busy` are already low.
- R11: `mem_rd_en` is never high in two consecutive cycles and is high only while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Bit-rate enable, one bit period per high cycle |
| start | input | 1 | Frame start request |
| cfg_base | input | 11 | First buffer address of the frame |
| cfg_len | input | 12 | Number of buffer bytes in the frame (0 to 2048) |
| cfg_stamp_en | input | 1 | Append the 16-bit timestamp after the buffer bytes |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_addr | output | 11 | Buffer read address |
| mem_rd_data | input | 8 | Buffer read data, valid one cycle after the strobe |
| pulse_en | output | 1 | On-off keying output to the pulse generator |
| on_air | output | 1 | A frame bit is being sent |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when the frame has ended |

## Verification
`busy` is due one cycle after the accepting edge, so the bench samples it on the falling edge right after driving `start`. Each frame bit appears one edge after the tick that launches it. The bench therefore records `pulse_en` at the falling edge after every tick edge, but only when `on_air` is high. Because of this, the varying wait for the first buffer read never shifts the compared sequence. `done` is checked in the same falling-edge window that first shows `on_air` low after the last tick, and then on the following cycles to confirm it does not repeat. Tick density varies from every cycle down to sparse, and the expected timestamp comes from the bench's own count of ticks driven before the accepting edge.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int unsigned BUF_BYTES   = 2048;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned STAMP_W     = 16;
    localparam int unsigned ADDR_W      = $clog2(BUF_BYTES);
    localparam int unsigned CNT_W       = ADDR_W + 1;
    localparam int unsigned STAMP_BYTES = STAMP_W / BYTE_W;
    localparam int unsigned BITPOS_W    = $clog2(BYTE_W);

    typedef logic [ADDR_W-1:0]   addr_t;
    typedef logic [CNT_W-1:0]    cnt_t;
    typedef logic [BYTE_W-1:0]   byte_t;
    typedef logic [STAMP_W-1:0]  stamp_t;
    typedef logic [BITPOS_W-1:0] bitpos_t;

    typedef enum logic [1:0] {
        PTX_IDLE  = 2'd0,
        PTX_PRIME = 2'd1,
        PTX_SEND  = 2'd2
    } ptx_state_e;

    typedef struct packed {
        addr_t base;
        cnt_t  count;
        logic  stamp_en;
    } ptx_cfg_t;

    // Byte slots in a frame: buffer bytes plus the trailing timestamp bytes.
    function automatic cnt_t slot_total(input ptx_cfg_t c);
        return c.count + (c.stamp_en ? cnt_t'(STAMP_BYTES) : cnt_t'(0));
    endfunction

    function automatic logic frame_empty(input ptx_cfg_t c);
        return (c.count == '0) && !c.stamp_en;
    endfunction

    // Timestamp byte k, counted from the most significant end.
    function automatic byte_t stamp_byte(input stamp_t s, input int unsigned k);
        return s[(STAMP_BYTES - 1 - k) * BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/ptx_stamp_clock.sv
module ptx_stamp_clock
    import ptx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_tick,
    input  logic   capture,
    output stamp_t stamp_q
);
    stamp_t free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q  <= '0;
            stamp_q <= '0;
        end else begin
            if (bit_tick) free_q <= free_q + 1'b1;
            if (capture)  stamp_q <= free_q;
        end
    end
endmodule

// File: rtl/ptx_fetch.sv
module ptx_fetch
    import ptx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     init,
    input  ptx_cfg_t cfg,
    input  stamp_t   stamp,
    input  logic     req,
    input  logic     consume,
    input  byte_t    mem_rd_data,
    output logic     mem_rd_en,
    output addr_t    mem_addr,
    output byte_t    hold_byte,
    output logic     hold_valid
);
    addr_t addr_q;
    cnt_t  idx_q;
    cnt_t  total_q;
    cnt_t  count_q;
    logic  cap_q;
    logic  more;

    assign more = (idx_q < total_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            idx_q      <= '0;
            total_q    <= '0;
            count_q    <= '0;
            cap_q      <= 1'b0;
            mem_rd_en  <= 1'b0;
            mem_addr   <= '0;
            hold_byte  <= '0;
            hold_valid <= 1'b0;
        end else begin
            mem_rd_en <= 1'b0;
            cap_q     <= mem_rd_en;
            if (consume) hold_valid <= 1'b0;
            if (init) begin
                addr_q     <= cfg.base;
                idx_q      <= '0;
                total_q    <= slot_total(cfg);
                count_q    <= cfg.count;
                hold_valid <= 1'b0;
            end else if (req && more) begin
                if (idx_q < count_q) begin
                    mem_rd_en <= 1'b1;
                    mem_addr  <= addr_q;
                    addr_q    <= addr_q + 1'b1;
                end else begin
                    hold_byte  <= stamp_byte(stamp, int'(idx_q - count_q));
                    hold_valid <= 1'b1;
                end
                idx_q <= idx_q + 1'b1;
            end
            if (cap_q) begin
                hold_byte  <= mem_rd_data;
                hold_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ptx_shifter.sv
module ptx_shifter
    import ptx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  shift,
    input  logic  clear,
    input  byte_t byte_in,
    output logic  bit_out,
    output logic  last_bit
);
    byte_t   sh_q;
    bitpos_t left_q;

    assign last_bit = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            left_q  <= '0;
            bit_out <= 1'b0;
        end else if (clear) begin
            bit_out <= 1'b0;
            left_q  <= '0;
        end else if (load) begin
            bit_out <= byte_in[BYTE_W-1];
            sh_q    <= {byte_in[BYTE_W-2:0], 1'b0};
            left_q  <= bitpos_t'(BYTE_W - 1);
        end else if (shift) begin
            bit_out <= sh_q[BYTE_W-1];
            sh_q    <= {sh_q[BYTE_W-2:0], 1'b0};
            left_q  <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/pulse_tx_serializer.sv
module pulse_tx_serializer
    import ptx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_len,
    input  logic              cfg_stamp_en,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              pulse_en,
    output logic              on_air,
    output logic              busy,
    output logic              done
);
    ptx_state_e state_q, state_d;
    ptx_cfg_t   cfg_in;
    stamp_t     stamp_q;
    byte_t      hold_byte;
    logic       hold_valid;
    logic       last_bit;
    logic       accept, kick_q;
    logic       load, shift, clear, consume, finish, req;
    logic       on_air_q, done_q;

    assign cfg_in = '{base: cfg_base, count: cfg_len, stamp_en: cfg_stamp_en};
    assign accept = (state_q == PTX_IDLE) && start && !frame_empty(cfg_in);
    assign req    = kick_q || load;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        shift   = 1'b0;
        clear   = 1'b0;
        consume = 1'b0;
        finish  = 1'b0;
        case (state_q)
            PTX_IDLE: begin
                if (accept) state_d = PTX_PRIME;
            end
            PTX_PRIME: begin
                if (bit_tick && hold_valid) begin
                    load    = 1'b1;
                    consume = 1'b1;
                    state_d = PTX_SEND;
                end
            end
            PTX_SEND: begin
                if (bit_tick) begin
                    if (!last_bit) begin
                        shift = 1'b1;
                    end else if (hold_valid) begin
                        load    = 1'b1;
                        consume = 1'b1;
                    end else begin
                        clear   = 1'b1;
                        finish  = 1'b1;
                        state_d = PTX_IDLE;
                    end
                end
            end
            default: state_d = PTX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PTX_IDLE;
            kick_q   <= 1'b0;
            on_air_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            kick_q  <= accept;
            done_q  <= finish;
            if (load)        on_air_q <= 1'b1;
            else if (finish) on_air_q <= 1'b0;
        end
    end

    ptx_stamp_clock u_stamp (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .capture  (accept),
        .stamp_q  (stamp_q)
    );

    ptx_fetch u_fetch (
        .clk         (clk),
        .rst         (rst),
        .init        (accept),
        .cfg         (cfg_in),
        .stamp       (stamp_q),
        .req         (req),
        .consume     (consume),
        .mem_rd_data (mem_rd_data),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .hold_byte   (hold_byte),
        .hold_valid  (hold_valid)
    );

    ptx_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .shift    (shift),
        .clear    (clear),
        .byte_in  (hold_byte),
        .bit_out  (pulse_en),
        .last_bit (last_bit)
    );

    assign on_air = on_air_q;
    assign done   = done_q;
    assign busy   = (state_q != PTX_IDLE);

endmodule

// File: rtl/ptx_checker.sv
module ptx_checker (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic busy,
    input logic on_air,
    input logic pulse_en,
    input logic done,
    input logic mem_rd_en
);
    AST_KEY_QUIET_OFF_AIR: assert property (@(posedge clk) disable iff (rst)
        !on_air |-> !pulse_en); // R5

    AST_KEY_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> ($stable(on_air) && $stable(pulse_en))); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_AFTER_AIR: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !on_air)); // R10

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R2

    AST_AIR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        on_air |-> busy); // R2

    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en); // R11

    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy); // R11
endmodule

bind pulse_tx_serializer ptx_checker u_ptx_checker (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .busy      (busy),
    .on_air    (on_air),
    .pulse_en  (pulse_en),
    .done      (done),
    .mem_rd_en (mem_rd_en)
);

// File: tb/pulse_tx_serializer_bench.sv
module pulse_tx_serializer_bench;
    import ptx_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bit_tick = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [CNT_W-1:0]  cfg_len = '0;
    logic              cfg_stamp_en = 1'b0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_rd_data;
    logic              pulse_en, on_air, busy, done;

    logic [7:0]  mem [BUF_BYTES];
    logic [15:0] tick_cnt = '0;
    logic        prev_tk = 1'b0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_addr];
    end

    pulse_tx_serializer u_pulse_tx_serializer (
        .clk          (clk),
        .rst          (rst),
        .bit_tick     (bit_tick),
        .start        (start),
        .cfg_base     (cfg_base),
        .cfg_len      (cfg_len),
        .cfg_stamp_en (cfg_stamp_en),
        .mem_rd_en    (mem_rd_en),
        .mem_addr     (mem_addr),
        .mem_rd_data  (mem_rd_data),
        .pulse_en     (pulse_en),
        .on_air       (on_air),
        .busy         (busy),
        .done         (done)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cyc);
                summary();
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one tick decision for the next edge; keeps the bench tick count.
    task automatic drive_tick(input int pct);
        logic tk;
        tk = ($urandom_range(99) < pct);
        bit_tick = tk;
        if (tk) tick_cnt = tick_cnt + 1'b1;
        prev_tk = tk;
    endtask

    task automatic idle_cycles(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            drive_tick(pct);
            @(negedge clk);
        end
    endtask

    task automatic run_frame(input int base, input int len, input bit stamp_en,
                             input int pct, input bit poke);
        logic [15:0] exp_stamp;
        logic [7:0]  exp_bytes[$];
        bit          got[$];
        bit          seen_done;
        int          dones, guard, bad_buf, bad_stamp, first_bad;
        bit          poked;
        exp_bytes.delete();
        got.delete();
        cfg_base     = ADDR_W'(base);
        cfg_len      = CNT_W'(len);
        cfg_stamp_en = stamp_en;
        start        = 1'b1;
        exp_stamp    = tick_cnt;
        drive_tick(pct);
        for (int i = 0; i < len; i++) exp_bytes.push_back(mem[(base + i) % BUF_BYTES]);
        if (stamp_en) begin
            exp_bytes.push_back(exp_stamp[15:8]);
            exp_bytes.push_back(exp_stamp[7:0]);
        end
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accepted start", busy, 1);
        seen_done = 0; dones = 0; guard = 0; poked = 0;
        while (!seen_done && guard < 40000) begin
            if (prev_tk && on_air) got.push_back(pulse_en);
            if (done) begin
                seen_done = 1;
                dones++;
                chk(!busy && !on_air && !pulse_en, "R10", "busy/on_air/pulse at done",
                    {busy, on_air, pulse_en}, 0);
            end
            if (!seen_done) begin
                start = 1'b0;
                if (poke && !poked && guard == 12 && busy) begin
                    start        = 1'b1;
                    cfg_base     = ADDR_W'(base + 100);
                    cfg_len      = CNT_W'(3);
                    cfg_stamp_en = ~stamp_en;
                    poked        = 1;
                end
                drive_tick(pct);
                guard++;
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(seen_done, "R10", "done observed", seen_done, 1);
        for (int i = 0; i < 4; i++) begin
            drive_tick(pct);
            @(negedge clk);
            if (done) dones++;
            chk(!busy, (poke ? "R9" : "R2"), "busy stays low after done", busy, 0);
        end
        chk(dones == 1, (poke ? "R9" : "R10"), "done pulse count", dones, 1);
        chk(got.size() == exp_bytes.size() * 8, "R4", "bit count", got.size(),
            exp_bytes.size() * 8);
        bad_buf = 0; bad_stamp = 0; first_bad = -1;
        for (int i = 0; i < got.size() && i < exp_bytes.size() * 8; i++) begin
            if (got[i] != exp_bytes[i / 8][7 - (i % 8)]) begin
                if (first_bad < 0) first_bad = i;
                if (i < len * 8) bad_buf++;
                else bad_stamp++;
            end
        end
        chk(bad_buf == 0, (poke ? "R9" : "R3"), "buffer bits wrong (first index)",
            first_bad, -1);
        if (stamp_en)
            chk(bad_stamp == 0, (len == 0 ? "R7" : "R6"), "timestamp bits wrong",
                bad_stamp, 0);
    endtask

    initial begin
        void'($urandom(32'h51A7_0C3D));
        for (int i = 0; i < BUF_BYTES; i++) mem[i] = 8'($urandom_range(255));
        mem[5] = 8'hA5;
        repeat (3) @(negedge clk);
        chk(!busy && !on_air && !pulse_en && !done && !mem_rd_en, "R1", "outputs in reset",
            {busy, on_air, pulse_en, done, mem_rd_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !on_air && !pulse_en && !done && !mem_rd_en, "R1", "outputs after reset",
            {busy, on_air, pulse_en, done, mem_rd_en}, 0);
        idle_cycles(7, 50);

        run_frame(5, 1, 0, 100, 0);       // R4 single byte, tick every cycle
        idle_cycles(3, 50);
        run_frame(2046, 4, 0, 50, 0);     // R3 address wrap
        idle_cycles(3, 50);

        // R8: empty frame request is ignored
        cfg_base = '0; cfg_len = '0; cfg_stamp_en = 1'b0; start = 1'b1;
        drive_tick(50);
        @(negedge clk);
        start = 1'b0;
        begin
            int dn;
            dn = 0;
            for (int i = 0; i < 6; i++) begin
                if (done || busy) dn++;
                drive_tick(50);
                @(negedge clk);
            end
            chk(dn == 0, "R8", "busy or done after empty start", dn, 0);
        end

        run_frame(0, 0, 1, 40, 0);        // R7 timestamp only
        idle_cycles(5, 60);
        run_frame(300, 4, 1, 30, 1);      // R6 + R9 start while busy
        idle_cycles(2, 50);
        run_frame(777, 2048, 1, 100, 0);  // R3 full buffer, ticks every cycle
        idle_cycles(2, 50);

        for (int f = 0; f < 6; f++) begin
            run_frame($urandom_range(BUF_BYTES - 1), $urandom_range(40, 1),
                      1'($urandom_range(1)), $urandom_range(100, 20),
                      1'($urandom_range(1)));
            idle_cycles($urandom_range(6), 50);
        end

        summary();
        $finish;
    end
endmodule